// File: doc/BRIEF.md
# Conditional Instruction Cycle Sequencer

This block is the issue and timing controller of a small trigger-logic processor. It takes one instruction at a time and holds the pipeline for a number of master clock cycles. That number depends on the opcode and on the instruction's condition flag. An instruction whose condition is false never waits on slow hardware and always finishes in the fixed minimum of two cycles. An executed instruction takes the latency of its opcode. An executed jump runs a fixed restart sequence, and during that sequence the block asks the pipeline to flush.

The fetch stage offers an instruction with a valid strobe. The block accepts it only when the pipeline reports ready and no earlier instruction is still in progress. While the instruction is in progress, `busy` stalls the fetch stage. The datapath starts its work on the one-cycle `exec_en` pulse. The single `done` pulse marks the last cycle of the instruction.

Top module: `cond_issue_seq`

## Requirements
- R1: An instruction is accepted at a clock edge where `instr_valid` and `pipe_ready` are both high and `busy` is low. `busy` is then high from the following cycle on.
- R2: An instruction with `cond_true` low occupies exactly 2 cycles for any opcode. It produces no `exec_en` and no `flush_req`.
- R3: An executed multiply-immediate instruction (opcode 4'h1) occupies 4 cycles.
- R4: Executed add (4'h2), subtract (4'h3) and logarithm (4'h4) instructions each occupy 3 cycles.
- R5: Every other executed opcode except the jump occupies 2 cycles.
- R6: An executed jump (opcode 4'hF) occupies exactly 11 cycles.
- R7: `flush_req` is high in cycles 2 through 10 of an executed jump, counting the first busy cycle as cycle 1. It is low at all other times.
- R8: `exec_en` pulses for exactly one cycle, in cycle 1 of the instruction, and only when `cond_true` was high at acceptance.
- R9: `done` is high for one cycle only, in the last busy cycle. `busy` is low in the cycle that follows.
- R10: `instr_valid` has no effect while `busy` is high or while `pipe_ready` is low. The length and outputs of the instruction in progress are unchanged.
- R11: When the synchronous active-high `rst` is applied, `busy`, `done`, `flush_req` and `exec_en` are all low after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction offered by fetch |
| opcode | input | 4 | Opcode of the offered instruction |
| cond_true | input | 1 | Condition of the offered instruction is met |
| pipe_ready | input | 1 | Pipeline can take a new instruction |
| busy | output | 1 | Instruction in progress; stalls fetch |
| exec_en | output | 1 | One-cycle execute strobe for the datapath |
| done | output | 1 | Last cycle of the instruction |
| flush_req | output | 1 | Pipeline flush request during a jump |

## Verification
The bench builds the block with its default latencies: a minimum of 2, multiply 4, arithmetic 3 and jump 11. With these values the longest case, the 11-cycle jump and its 9-cycle flush window, fits in a short per-instruction observation window. Random instructions carry random noise strobes while busy, which reaches the ignore rule (R10) on every opcode. Directed cases cover every opcode class with the condition both true and false, a strobe held off by `pipe_ready`, and a reset applied in the middle of a jump.

// File: rtl/cond_issue_seq.sv
module cond_issue_seq #(
  parameter int OPW       = 4,
  parameter int MIN_CYC   = 2,
  parameter int MUL_CYC   = 4,
  parameter int ARITH_CYC = 3,
  parameter int JUMP_CYC  = 11,
  parameter logic [OPW-1:0] OP_MUL  = 4'h1,
  parameter logic [OPW-1:0] OP_ADD  = 4'h2,
  parameter logic [OPW-1:0] OP_SUB  = 4'h3,
  parameter logic [OPW-1:0] OP_LOG  = 4'h4,
  parameter logic [OPW-1:0] OP_JUMP = 4'hF
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           instr_valid,
  input  logic [OPW-1:0] opcode,
  input  logic           cond_true,
  input  logic           pipe_ready,
  output logic           busy,
  output logic           exec_en,
  output logic           done,
  output logic           flush_req
);
  localparam int CW          = $clog2(JUMP_CYC + 1);
  localparam int FLUSH_FIRST = 2;
  localparam int FLUSH_LAST  = JUMP_CYC - 1;

  logic          active;
  logic [CW-1:0] cnt, len_q;
  logic          exec_q, jump_q;
  logic          accept;

  function automatic logic [CW-1:0] len_of(input logic [OPW-1:0] op, input logic c);
    if (!c)                                   return CW'(MIN_CYC);
    else if (op == OP_MUL)                    return CW'(MUL_CYC);
    else if (op == OP_ADD || op == OP_SUB ||
             op == OP_LOG)                    return CW'(ARITH_CYC);
    else if (op == OP_JUMP)                   return CW'(JUMP_CYC);
    else                                      return CW'(MIN_CYC);
  endfunction

  assign accept = !active && instr_valid && pipe_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      cnt    <= '0;
      len_q  <= '0;
      exec_q <= 1'b0;
      jump_q <= 1'b0;
    end else if (!active) begin
      if (accept) begin
        active <= 1'b1;
        cnt    <= CW'(1);
        len_q  <= len_of(opcode, cond_true);
        exec_q <= cond_true;
        jump_q <= cond_true && (opcode == OP_JUMP);
      end
    end else if (cnt == len_q) begin
      active <= 1'b0;
      cnt    <= '0;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end

  assign busy      = active;
  assign done      = active && (cnt == len_q);
  assign exec_en   = active && exec_q && (cnt == CW'(1));
  assign flush_req = active && jump_q &&
                     (cnt >= CW'(FLUSH_FIRST)) && (cnt <= CW'(FLUSH_LAST));

  a_r1_accept: assert property (@(posedge clk) disable iff (rst)
    (!busy && instr_valid && pipe_ready) |=> busy);
  a_r2_min_two: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !done);
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> busy);
  a_r9_done_ends: assert property (@(posedge clk) disable iff (rst)
    done |=> !busy);
  a_r8_exec_single: assert property (@(posedge clk) disable iff (rst)
    exec_en |=> !exec_en);
  a_r8_exec_first: assert property (@(posedge clk) disable iff (rst)
    exec_en |-> $rose(busy));
  a_r7_flush_inside: assert property (@(posedge clk) disable iff (rst)
    flush_req |-> (busy && !done && !$rose(busy)));
  a_r11_reset: assert property (@(posedge clk)
    rst |=> (!busy && !done && !flush_req && !exec_en));
endmodule

// File: tb/sim_cond_issue_seq.sv
`timescale 1ns/1ps
module sim_cond_issue_seq;
  logic clk = 1'b0, rst = 1'b1;
  logic instr_valid = 1'b0, cond_true = 1'b0, pipe_ready = 1'b0;
  logic [3:0] opcode = 4'h0;
  logic busy, exec_en, done, flush_req;
  int checks = 0, failures = 0;

  always #4 clk = ~clk;

  cond_issue_seq u0 (.clk(clk), .rst(rst), .instr_valid(instr_valid), .opcode(opcode),
    .cond_true(cond_true), .pipe_ready(pipe_ready), .busy(busy), .exec_en(exec_en),
    .done(done), .flush_req(flush_req));

  function automatic int exp_len(input logic [3:0] op, input logic c);
    if (!c) return 2;
    case (op)
      4'h1: return 4;
      4'h2, 4'h3, 4'h4: return 3;
      4'hF: return 11;
      default: return 2;
    endcase
  endfunction

  function automatic string len_tag(input logic [3:0] op, input logic c);
    if (!c) return "R2";
    case (op)
      4'h1: return "R3";
      4'h2, 4'h3, 4'h4: return "R4";
      4'hF: return "R6";
      default: return "R5";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic run_instr(input logic [3:0] op, input logic c, input bit noise);
    int len = 0, ex_cnt = 0, ex_pos = 0, dn_cnt = 0, dn_pos = 0;
    int fl_cnt = 0, fl_first = 0, fl_last = 0;
    bit ended = 0;
    int elen = exp_len(op, c);
    bit jmp = c && (op == 4'hF);
    @(negedge clk);
    instr_valid = 1'b1; opcode = op; cond_true = c; pipe_ready = 1'b1;
    for (int k = 1; k <= 16 && !ended; k++) begin
      @(negedge clk);
      if (!busy) begin
        ended = 1;
      end else begin
        len++;
        if (exec_en) begin ex_cnt++; ex_pos = k; end
        if (done) begin dn_cnt++; dn_pos = k; end
        if (flush_req) begin fl_cnt++; if (fl_first == 0) fl_first = k; fl_last = k; end
      end
      if (done || !noise) instr_valid = 1'b0;
      else begin
        instr_valid = 1'($urandom);
        opcode = 4'($urandom);
        cond_true = 1'($urandom);
        pipe_ready = 1'($urandom);
      end
    end
    instr_valid = 1'b0; pipe_ready = 1'b1;
    check(len == elen, len_tag(op, c), len, elen);
    if (noise) check(len == elen, "R10", len, elen);
    check(ex_cnt == (c ? 1 : 0), "R8", ex_cnt, c ? 1 : 0);
    if (c) check(ex_pos == 1, "R8", ex_pos, 1);
    check(dn_cnt == 1 && dn_pos == elen, "R9", dn_pos, elen);
    check(ended, "R9", ended, 1);
    check(fl_cnt == (jmp ? 9 : 0), "R7", fl_cnt, jmp ? 9 : 0);
    if (jmp) check(fl_first == 2 && fl_last == 10, "R7", fl_first * 100 + fl_last, 210);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [3:0] ops [8] = '{4'h0, 4'h1, 4'h2, 4'h3, 4'h4, 4'h5, 4'hE, 4'hF};
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    check(!busy && !done && !flush_req && !exec_en, "R11", busy, 0);

    foreach (ops[i]) begin
      run_instr(ops[i], 1'b1, 1'b0);
      run_instr(ops[i], 1'b0, 1'b0);
    end

    // R10: strobe held off by pipe_ready
    @(negedge clk);
    instr_valid = 1'b1; opcode = 4'hF; cond_true = 1'b1; pipe_ready = 1'b0;
    @(negedge clk);
    check(!busy && !exec_en, "R10", busy, 0);
    instr_valid = 1'b0; pipe_ready = 1'b1;

    // R1: back-to-back acceptance right after busy drops
    run_instr(4'h2, 1'b1, 1'b0);
    run_instr(4'h1, 1'b1, 1'b0);

    for (int n = 0; n < 60; n++)
      run_instr(4'($urandom), 1'($urandom), 1'b1);

    // R11: reset in the middle of a jump
    @(negedge clk);
    instr_valid = 1'b1; opcode = 4'hF; cond_true = 1'b1; pipe_ready = 1'b1;
    @(negedge clk);
    instr_valid = 1'b0;
    check(busy, "R1", busy, 1);
    repeat (3) @(negedge clk);
    check(flush_req, "R7", flush_req, 1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(!busy && !done && !flush_req && !exec_en, "R11",
          {busy, done, flush_req, exec_en}, 0);
    @(negedge clk);
    check(!busy, "R11", busy, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule